// File: doc/BRIEF.md
# Dual-Mode I/O Window Translator

This block is a memory-mapped slave. It claims CPU accesses that fall inside an 8 MB I/O window at CPU address 0x8000_0000. Each claimed access is forwarded to a downstream I/O bus at a translated address. The offset inside the window is reduced to a downstream offset, and a fixed I/O base of 0x8000_0000 is added to it. The transfer then goes out through a request/acknowledge handshake. The CPU is released only when the downstream side acknowledges.

A level input chooses between two translations:

- **Contiguous (level low):** only the lowest 16 offset bits are kept, which gives a flat 64 KB space.
- **Sparse (level high):** offset bits [4:0] are kept, bits [11:5] are discarded, and the page bits [22:12] are placed directly above the kept bits. Each 4 KB page of the window therefore maps to 32 consecutive downstream bytes.

Transfers carry 1, 2 or 4 little-endian bytes. Lanes beyond the access size are zeroed on the write path and on the read path. Addresses may be unaligned.

Top module: `iowin_xlate`

## Requirements
- R1: After reset `io_req_o` and `cpu_ack_o` are low. The block is idle and translates in contiguous mode until the mode input is seen high while idle.
- R2: A CPU request whose address has bits [31:23] different from those of 0x8000_0000 is not claimed. No downstream request and no CPU acknowledge result, however long the request is held.
- R3: With the mode input low at acceptance, `io_addr_o` equals 0x8000_0000 plus the window offset taken modulo 65536.
- R4: With the mode input high at acceptance, `io_addr_o` equals 0x8000_0000 plus (offset mod 32) plus 32 times (offset divided by 4096, rounded down).
- R5: The mode input is sampled only while idle. Toggling it while a transfer is outstanding leaves that transfer's downstream address unchanged. The next transfer uses the new level.
- R6: `io_req_o` rises on the clock edge that accepts a request. It then stays high with a stable address, size, direction and write data until the edge on which `io_ack_i` is seen high.
- R7: On the edge where `io_ack_i` is seen with `io_req_o` high, `io_req_o` falls and `cpu_ack_o` rises. `cpu_ack_o` stays high for exactly one cycle, after which the block is idle again.
- R8: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is treated as 4 bytes. `io_size_o` carries the normalised code.
- R9: Write data is forwarded with byte lanes at or above the access size set to zero. A read returns `io_rdata_i` zero-extended from the access size. A write returns zero on `cpu_rdata_o`.
- R10: Unaligned addresses pass through the translation unchanged in their low bits, for example a 4-byte access at an offset ending in 3. `io_we_o` follows the CPU direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| map_sparse_i | input | 1 | Mode level: 0 selects contiguous, 1 selects sparse |
| cpu_req_i | input | 1 | CPU access request, held until acknowledged |
| cpu_we_i | input | 1 | 1 for write, 0 for read |
| cpu_addr_i | input | 32 | CPU byte address |
| cpu_size_i | input | 2 | Size code (0 = 1 B, 1 = 2 B, 2 or 3 = 4 B) |
| cpu_wdata_i | input | 32 | Write data, little-endian |
| cpu_ack_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 32 | Read data, zero-extended |
| io_req_o | output | 1 | Downstream request |
| io_we_o | output | 1 | Downstream direction |
| io_addr_o | output | 32 | Translated downstream address |
| io_size_o | output | 2 | Normalised size code |
| io_wdata_o | output | 32 | Lane-masked write data |
| io_ack_i | input | 1 | Downstream acknowledge |
| io_rdata_i | input | 32 | Downstream read data |

## Verification
The hardest case to provoke from the ports is a mode change landing while a transfer is stalled. The stale and the fresh address differ only if the offset translates differently in the two modes. The bench holds the acknowledge off for several cycles, flips the mode level during the stall, and picks offsets above 64 KB where the two translations differ. It then confirms that the address never moved and that the following access follows the new level. Random accesses across the whole window, with random stall lengths, sizes and directions, cover the folding arithmetic.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } iowin_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Map the raw size code onto the three legal transfer sizes.
  function automatic logic [1:0] size_norm(input logic [1:0] code);
    return (code == 2'd3) ? SZ_WORD : code;
  endfunction

  // Number of bytes a normalised size code moves.
  function automatic int unsigned size_bytes(input logic [1:0] code);
    return 1 << code;
  endfunction

endpackage

// File: rtl/iowin_mode_latch.sv
module iowin_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic mode_in_i,
  output logic mode_q_o,
  output logic mode_eff_o
);

  // Follow the pin only while idle; freeze during a transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q_o <= 1'b0;
    else if (!busy_i) mode_q_o <= mode_in_i;
  end

  // Mode used for translation: the live pin when idle, the held level otherwise.
  assign mode_eff_o = busy_i ? mode_q_o : mode_in_i;

  // R5: the held mode cannot move while a transfer is outstanding
  assert_mode_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(mode_q_o));

endmodule

// File: rtl/iowin_addr_fold.sv
module iowin_addr_fold #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned WIN_LOG2    = 23,
  parameter int unsigned CONTIG_BITS = 16,
  parameter int unsigned KEEP_BITS   = 5,
  parameter int unsigned PAGE_LSB    = 12,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'h8000_0000
) (
  input  logic [WIN_LOG2-1:0] off_i,
  input  logic                sparse_i,
  output logic [ADDR_W-1:0]   io_addr_o
);

  localparam int unsigned PAGE_W = WIN_LOG2 - PAGE_LSB;
  localparam int unsigned SPARSE_W = KEEP_BITS + PAGE_W;

  // Flat mapping: keep only the low CONTIG_BITS offset bits.
  function automatic logic [ADDR_W-1:0] fold_contig(input logic [WIN_LOG2-1:0] off);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[CONTIG_BITS-1:0] = off[CONTIG_BITS-1:0];
    return r;
  endfunction

  // Sparse mapping: keep the byte bits, drop the gap, pack the page index above.
  function automatic logic [ADDR_W-1:0] fold_sparse(input logic [WIN_LOG2-1:0] off);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[KEEP_BITS-1:0]        = off[KEEP_BITS-1:0];
    r[SPARSE_W-1:KEEP_BITS] = off[WIN_LOG2-1:PAGE_LSB];
    return r;
  endfunction

  logic [ADDR_W-1:0] off_contig, off_sparse;

  always_comb begin
    off_contig = fold_contig(off_i);
    off_sparse = fold_sparse(off_i);
    io_addr_o  = IO_BASE + (sparse_i ? off_sparse : off_contig);
  end

endmodule

// File: rtl/iowin_lane_mask.sv
module iowin_lane_mask #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned NBYTES = DATA_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic keep;
    assign keep = (b < iowin_pkg::size_bytes(size_i));
    assign data_o[8*b +: 8] = keep ? data_i[8*b +: 8] : 8'h00;
  end

endmodule

// File: rtl/iowin_seq.sv
module iowin_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_i,
  input  logic              in_win_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] xaddr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              io_ack_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              io_req_o,
  output logic              io_we_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [1:0]        io_size_o,
  output logic [DATA_W-1:0] io_wdata_o,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o
);
  import iowin_pkg::*;

  iowin_state_e state_q;
  logic         io_done;

  assign accept_o = (state_q == ST_IDLE) && cpu_req_i && in_win_i;
  assign io_done  = (state_q == ST_WAIT) && io_ack_i;
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      io_req_o    <= 1'b0;
      io_we_o     <= 1'b0;
      io_addr_o   <= '0;
      io_size_o   <= SZ_BYTE;
      io_wdata_o  <= '0;
      cpu_ack_o   <= 1'b0;
      cpu_rdata_o <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cpu_ack_o <= 1'b0;
          if (accept_o) begin
            io_req_o   <= 1'b1;
            io_we_o    <= cpu_we_i;
            io_addr_o  <= xaddr_i;
            io_size_o  <= size_i;
            io_wdata_o <= wdata_i;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (io_done) begin
            io_req_o    <= 1'b0;
            cpu_ack_o   <= 1'b1;
            cpu_rdata_o <= io_we_o ? '0 : rdata_i;
            state_q     <= ST_DONE;
          end
        end
        ST_DONE: begin
          cpu_ack_o <= 1'b0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an unclaimed request never opens a downstream transfer
  assert_no_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cpu_req_i && !in_win_i) |=> !io_req_o);

  // R6: request held with stable attributes until acknowledged
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_o && !io_ack_i) |=> (io_req_o && $stable(io_addr_o) && $stable(io_size_o)
                                 && $stable(io_wdata_o) && $stable(io_we_o)));

  // R6: acceptance raises the request on the next cycle
  assert_req_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> io_req_o);

  // R7: acknowledge turns into CPU completion and drops the request
  assert_ack_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_o && io_ack_i) |=> (cpu_ack_o && !io_req_o));

  // R7: completion is a single-cycle pulse
  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack_o |=> !cpu_ack_o);

  // R9: a byte transfer never drives the upper write lanes
  assert_wlane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_o && io_size_o == SZ_BYTE) |-> (io_wdata_o[DATA_W-1:8] == '0));

endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned WIN_LOG2    = 23,
  parameter int unsigned CONTIG_BITS = 16,
  parameter int unsigned KEEP_BITS   = 5,
  parameter int unsigned PAGE_LSB    = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] IO_BASE  = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_sparse_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [1:0]        cpu_size_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              io_req_o,
  output logic              io_we_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [1:0]        io_size_o,
  output logic [DATA_W-1:0] io_wdata_o,
  input  logic              io_ack_i,
  input  logic [DATA_W-1:0] io_rdata_i
);

  logic                in_win;
  logic [WIN_LOG2-1:0] win_off;
  logic [1:0]          size_n;
  logic                busy, accept, mode_q, mode_eff;
  logic [ADDR_W-1:0]   xaddr;
  logic [DATA_W-1:0]   wdata_m, rdata_m;

  assign in_win  = (cpu_addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign win_off = cpu_addr_i[WIN_LOG2-1:0];
  assign size_n  = iowin_pkg::size_norm(cpu_size_i);

  iowin_mode_latch u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy),
    .mode_in_i  (map_sparse_i),
    .mode_q_o   (mode_q),
    .mode_eff_o (mode_eff)
  );

  iowin_addr_fold #(
    .ADDR_W      (ADDR_W),
    .WIN_LOG2    (WIN_LOG2),
    .CONTIG_BITS (CONTIG_BITS),
    .KEEP_BITS   (KEEP_BITS),
    .PAGE_LSB    (PAGE_LSB),
    .IO_BASE     (IO_BASE)
  ) u_fold (
    .off_i     (win_off),
    .sparse_i  (mode_eff),
    .io_addr_o (xaddr)
  );

  iowin_lane_mask #(.DATA_W(DATA_W)) u_wmask (
    .size_i (size_n),
    .data_i (cpu_wdata_i),
    .data_o (wdata_m)
  );

  iowin_lane_mask #(.DATA_W(DATA_W)) u_rmask (
    .size_i (io_size_o),
    .data_i (io_rdata_i),
    .data_o (rdata_m)
  );

  iowin_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req_i   (cpu_req_i),
    .in_win_i    (in_win),
    .cpu_we_i    (cpu_we_i),
    .xaddr_i     (xaddr),
    .size_i      (size_n),
    .wdata_i     (wdata_m),
    .rdata_i     (rdata_m),
    .io_ack_i    (io_ack_i),
    .busy_o      (busy),
    .accept_o    (accept),
    .io_req_o    (io_req_o),
    .io_we_o     (io_we_o),
    .io_addr_o   (io_addr_o),
    .io_size_o   (io_size_o),
    .io_wdata_o  (io_wdata_o),
    .cpu_ack_o   (cpu_ack_o),
    .cpu_rdata_o (cpu_rdata_o)
  );

  // R3: contiguous translation never leaves the 64 KB slice above the I/O base
  assert_contig_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mode_eff) |=> (io_addr_o - IO_BASE) < (1 << CONTIG_BITS));

  // R10: the low byte-address bits survive translation in both modes
  assert_low_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (io_addr_o[KEEP_BITS-1:0] == $past(cpu_addr_i[KEEP_BITS-1:0])));

  // R1: sampled mode is contiguous until seen high while idle
  assert_mode_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !map_sparse_i) |=> !mode_q);

endmodule

// File: tb/iowin_xlate_tb_top.sv
module iowin_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_sparse_i = 1'b0;
  logic        cpu_req_i = 1'b0;
  logic        cpu_we_i = 1'b0;
  logic [31:0] cpu_addr_i = '0;
  logic [1:0]  cpu_size_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic        cpu_ack_o;
  logic [31:0] cpu_rdata_o;
  logic        io_req_o, io_we_o;
  logic [31:0] io_addr_o;
  logic [1:0]  io_size_o;
  logic [31:0] io_wdata_o;
  logic        io_ack_i = 1'b0;
  logic [31:0] io_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iowin_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .map_sparse_i(map_sparse_i),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_size_i(cpu_size_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_ack_o(cpu_ack_o), .cpu_rdata_o(cpu_rdata_o),
    .io_req_o(io_req_o), .io_we_o(io_we_o), .io_addr_o(io_addr_o),
    .io_size_o(io_size_o), .io_wdata_o(io_wdata_o),
    .io_ack_i(io_ack_i), .io_rdata_i(io_rdata_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected downstream address, written with division and remainder.
  function automatic logic [31:0] exp_addr(input logic [31:0] cpu_a, input bit sparse);
    int unsigned off;
    off = cpu_a - 32'h8000_0000;
    if (sparse) return 32'h8000_0000 + (off % 32) + 32 * (off / 4096);
    return 32'h8000_0000 + (off % 65536);
  endfunction

  function automatic int unsigned nbytes(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] trim(input logic [31:0] d, input logic [1:0] code);
    int unsigned n;
    n = nbytes(code);
    if (n == 4) return d;
    return d % (32'd1 << (8 * n));
  endfunction

  function automatic logic [1:0] exp_size(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  // One complete access. When flip is set, the mode pin toggles during the stall.
  task automatic access(input bit we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] rd,
                        input bit sparse, input int stall, input bit flip);
    logic [31:0] ea;
    ea = exp_addr(a, sparse);
    @(negedge clk);
    map_sparse_i = sparse; cpu_req_i = 1'b1; cpu_we_i = we;
    cpu_addr_i = a; cpu_size_i = sz; cpu_wdata_i = wd;
    @(negedge clk);
    chk(io_req_o == 1'b1, "R6 req raised", {31'd0, io_req_o}, 32'd1);
    chk(io_addr_o == ea, sparse ? "R4 sparse addr" : "R3 contig addr", io_addr_o, ea);
    chk(io_size_o == exp_size(sz), "R8 size code", {30'd0, io_size_o}, {30'd0, exp_size(sz)});
    chk(io_we_o == we, "R10 direction", {31'd0, io_we_o}, {31'd0, we});
    if (we) chk(io_wdata_o == trim(wd, exp_size(sz)), "R9 write lanes", io_wdata_o, trim(wd, exp_size(sz)));
    for (int i = 0; i < stall; i++) begin
      if (flip) map_sparse_i = ~map_sparse_i;
      @(negedge clk);
      chk(io_req_o && io_addr_o == ea, "R5/R6 held during stall", io_addr_o, ea);
      chk(cpu_ack_o == 1'b0, "R7 no early ack", {31'd0, cpu_ack_o}, 32'd0);
    end
    io_ack_i = 1'b1; io_rdata_i = rd;
    @(negedge clk);
    io_ack_i = 1'b0;
    chk(cpu_ack_o == 1'b1 && io_req_o == 1'b0, "R7 handoff", {30'd0, cpu_ack_o, io_req_o}, 32'd2);
    if (we) chk(cpu_rdata_o == 32'd0, "R9 write returns zero", cpu_rdata_o, 32'd0);
    else    chk(cpu_rdata_o == trim(rd, exp_size(sz)), "R9 read extend", cpu_rdata_o, trim(rd, exp_size(sz)));
    cpu_req_i = 1'b0;
    @(negedge clk);
    chk(cpu_ack_o == 1'b0, "R7 pulse ends", {31'd0, cpu_ack_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(io_req_o == 1'b0 && cpu_ack_o == 1'b0, "R1 reset outputs", {30'd0, io_req_o, cpu_ack_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(io_req_o == 1'b0, "R1 idle after reset", {31'd0, io_req_o}, 32'd0);

    // R2: out-of-window requests are ignored
    cpu_req_i = 1'b1; cpu_addr_i = 32'h7FFF_FFFC; cpu_size_i = 2'd2;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(io_req_o == 1'b0 && cpu_ack_o == 1'b0, "R2 below window", {30'd0, io_req_o, cpu_ack_o}, 32'd0);
    end
    cpu_addr_i = 32'h8080_0000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(io_req_o == 1'b0 && cpu_ack_o == 1'b0, "R2 above window", {30'd0, io_req_o, cpu_ack_o}, 32'd0);
    end
    cpu_req_i = 1'b0;

    // R3 / R4 directed corners
    access(1'b0, 32'h8000_0000, 2'd0, 32'h0, 32'hA5B6C7D8, 1'b0, 0, 1'b0);
    access(1'b0, 32'h807F_FFFF, 2'd0, 32'h0, 32'h11223344, 1'b0, 1, 1'b0);
    access(1'b1, 32'h807F_FFFF, 2'd1, 32'hDEADBEEF, 32'h0, 1'b1, 0, 1'b0);
    access(1'b1, 32'h8000_1FE3, 2'd2, 32'hCAFEF00D, 32'h0, 1'b1, 2, 1'b0);
    // R10 unaligned word, R8 size code 3
    access(1'b0, 32'h8012_3003, 2'd3, 32'h0, 32'h89ABCDEF, 1'b0, 0, 1'b0);
    access(1'b0, 32'h8012_3003, 2'd1, 32'h0, 32'h89ABCDEF, 1'b1, 0, 1'b0);

    // R5: mode flips while stalled; address fixed at acceptance
    access(1'b0, 32'h8034_5678, 2'd2, 32'h0, 32'h01020304, 1'b0, 3, 1'b1);
    access(1'b1, 32'h8034_5678, 2'd0, 32'hFFFFFFFF, 32'h0, 1'b1, 5, 1'b1);
    // R5: the next access follows the newly sampled level
    access(1'b0, 32'h8034_5678, 2'd2, 32'h0, 32'h55AA55AA, 1'b1, 0, 1'b0);
    access(1'b0, 32'h8034_5678, 2'd2, 32'h0, 32'h55AA55AA, 1'b0, 0, 1'b0);

    // Random traffic across the whole window
    for (int n = 0; n < 80; n++) begin
      logic [31:0] a;
      a = 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
      access($urandom % 2, a, 2'($urandom % 4), $urandom, $urandom,
             $urandom % 2, $urandom % 4, $urandom % 2);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule